// File: doc/BRIEF.md
# ADC Conversion Sequence Controller

This block runs an external successive-approximation converter through programmed conversion sequences. A single 8-bit control register sets four things: where the sequence starts, whether the channel steps from one conversion to the next, whether sequences repeat, and how each result is formatted. For each conversion the block drives a channel number and a one-cycle start pulse. It then waits for the converter's done pulse and stores the 10-bit code, formatted, in a numbered 16-bit result slot. A flag reports that a full sequence has landed.

The number of conversions in a sequence comes from a separate length input, coded as length minus one. Writing the control register at any moment cancels the sequence in progress and begins a new one with the new settings. If a conversion was still in flight when the write came, its done pulse is absorbed and thrown away, and no new start is issued before that pulse arrives.

Top module: `adcSeqCtrl`

## Requirements
- R1: The control register resets to 0x00 and is writable at any time. Bit 7 selects right justification, bit 6 selects signed form, bit 5 enables continuous scan, bit 4 enables channel stepping and bits 2..0 hold the start channel. Bit 3 always reads 0.
- R2: A control write made while the block is idle drives convStart high with the new start channel in the cycle after the write.
- R3: With bit 5 clear, exactly one sequence is run and then no further start pulses are issued.
- R4: With bit 5 set, sequences follow one another with no further writes, and each new sequence begins again at the start channel.
- R5: With bit 4 clear, every conversion of the sequence uses the start channel.
- R6: With bit 4 set, conversion n of the sequence uses channel (start + n) mod 8, so channel 7 is followed by channel 0.
- R7: A sequence holds seqLenCode + 1 conversions (1 to 8).
- R8: The stored result for a raw code d is {d, 6'b0} when bits 7 and 6 are both clear, and {~d[9], d[8:0], 6'b0} when bit 7 is clear and bit 6 is set. When bit 7 is set it is {6'b0, d}, whatever the value of bit 6.
- R9: The result of conversion n is stored in slot n, read through resultRdIdx. seqComplete rises when the last slot of a sequence is written and clears on any control write.
- R10: A write during an outstanding conversion discards that conversion's done pulse, stores nothing from it, and issues no start before that pulse has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Control register write strobe |
| regWrData | input | 8 | Control register write data |
| regRdData | output | 8 | Control register read value |
| seqLenCode | input | 3 | Conversions per sequence minus one |
| convChannel | output | 3 | Channel for the current conversion |
| convStart | output | 1 | One-cycle start pulse to the converter |
| convDone | input | 1 | One-cycle done pulse from the converter |
| convData | input | 10 | Raw code, valid with convDone |
| resultRdIdx | input | 3 | Result slot select |
| resultRdData | output | 16 | Formatted content of the selected slot |
| seqComplete | output | 1 | Sequence-complete flag |

## Verification
The hardest case to reach from the ports is an abort that leaves a conversion in flight. This happens when the write lands in the cycle of the start pulse or while the converter is still working. To reach it, the bench's converter model answers each start after a fixed latency, and a second write is aimed at the start cycle and at a cycle inside the wait. Every raw code depends on a running conversion serial number, so a stored stale result cannot match the expected value. The model also counts any start pulse that arrives while an earlier conversion is still outstanding.

// File: rtl/adcSeqPkg.sv
package adcSeqPkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_START = 2'd1,
    SEQ_WAIT  = 2'd2,
    SEQ_DRAIN = 2'd3
  } seqState_t;

  typedef struct packed {
    logic store;   // capture convData into the current slot and step
    logic rescan;  // scan mode: reload counters for the next sequence
  } seqStrobe_t;

  localparam logic [7:0] CTRL_WR_MASK = 8'hF7;
  localparam int CTRL_RJUST = 7;
  localparam int CTRL_SIGN  = 6;
  localparam int CTRL_SCAN  = 5;
  localparam int CTRL_MULTI = 4;

endpackage

// File: rtl/adcResultFmt.sv
module adcResultFmt #(
  parameter int RAW_W  = 10,
  parameter int SLOT_W = 16
) (
  input  logic [RAW_W-1:0]  rawIn,
  input  logic              rightJust,
  input  logic              signedSel,
  output logic [SLOT_W-1:0] fmtOut
);
  localparam int PAD_W = SLOT_W - RAW_W;

  logic [RAW_W-1:0] flipped;

  // Signed form only exists for left-justified data.
  always_comb begin
    flipped = rawIn;
    flipped[RAW_W-1] = rawIn[RAW_W-1] ^ signedSel;
    if (rightJust) fmtOut = {{PAD_W{1'b0}}, rawIn};
    else           fmtOut = {flipped, {PAD_W{1'b0}}};
  end
endmodule

// File: rtl/adcSeqControl.sv
module adcSeqControl
  import adcSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic       convDone,
  input  logic       lastConv,
  input  logic       scanEn,
  output logic       convStart,
  output seqStrobe_t strobe
);
  seqState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    if (regWrEn) begin
      // A conversion is outstanding if a start was issued and its done has
      // not yet been seen; such a done must be absorbed first.
      if (stateQ == SEQ_START ||
          ((stateQ == SEQ_WAIT || stateQ == SEQ_DRAIN) && !convDone))
        stateD = SEQ_DRAIN;
      else
        stateD = SEQ_START;
    end else begin
      unique case (stateQ)
        SEQ_IDLE:  stateD = SEQ_IDLE;
        SEQ_START: stateD = SEQ_WAIT;
        SEQ_WAIT: begin
          if (convDone) begin
            strobe.store = 1'b1;
            if (lastConv) begin
              if (scanEn) begin
                strobe.rescan = 1'b1;
                stateD = SEQ_START;
              end else begin
                stateD = SEQ_IDLE;
              end
            end else begin
              stateD = SEQ_START;
            end
          end
        end
        SEQ_DRAIN: if (convDone) stateD = SEQ_START;
        default:   stateD = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= SEQ_IDLE;
    else       stateQ <= stateD;
  end

  assign convStart = (stateQ == SEQ_START);
endmodule

// File: rtl/adcSeqDatapath.sv
module adcSeqDatapath
  import adcSeqPkg::*;
#(
  parameter int CHAN_W    = 3,
  parameter int RAW_W     = 10,
  parameter int SLOT_W    = 16,
  parameter int NUM_SLOTS = 8,
  parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  input  seqStrobe_t        strobe,
  input  logic [IDX_W-1:0]  seqLenCode,
  input  logic [RAW_W-1:0]  convData,
  input  logic [IDX_W-1:0]  resultRdIdx,
  output logic [7:0]        regRdData,
  output logic [CHAN_W-1:0] convChannel,
  output logic [SLOT_W-1:0] resultRdData,
  output logic              seqComplete,
  output logic              lastConv,
  output logic              scanEn
);
  logic [7:0]        ctrlQ;
  logic [CHAN_W-1:0] chanQ;
  logic [IDX_W-1:0]  idxQ;
  logic [SLOT_W-1:0] fmtWord;
  logic [SLOT_W-1:0] slotQ [NUM_SLOTS];
  logic              multiEn;
  logic [CHAN_W-1:0] startChan;

  assign multiEn   = ctrlQ[CTRL_MULTI];
  assign scanEn    = ctrlQ[CTRL_SCAN];
  assign startChan = ctrlQ[CHAN_W-1:0];
  assign lastConv  = (idxQ == seqLenCode);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ       <= '0;
      chanQ       <= '0;
      idxQ        <= '0;
      seqComplete <= 1'b0;
    end else if (regWrEn) begin
      ctrlQ       <= regWrData & CTRL_WR_MASK;
      chanQ       <= regWrData[CHAN_W-1:0];
      idxQ        <= '0;
      seqComplete <= 1'b0;
    end else begin
      if (strobe.store && lastConv) seqComplete <= 1'b1;
      if (strobe.rescan) begin
        chanQ <= startChan;
        idxQ  <= '0;
      end else if (strobe.store) begin
        if (multiEn) chanQ <= chanQ + 1'b1;
        idxQ <= idxQ + 1'b1;
      end
    end
  end

  adcResultFmt #(.RAW_W(RAW_W), .SLOT_W(SLOT_W)) u_fmt (
    .rawIn     (convData),
    .rightJust (ctrlQ[CTRL_RJUST]),
    .signedSel (ctrlQ[CTRL_SIGN]),
    .fmtOut    (fmtWord)
  );

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) slotQ[g] <= '0;
      else if (strobe.store && !regWrEn && (idxQ == IDX_W'(g)))
        slotQ[g] <= fmtWord;
    end
  end

  assign regRdData    = ctrlQ;
  assign convChannel  = chanQ;
  assign resultRdData = slotQ[resultRdIdx];
endmodule

// File: rtl/adcSeqCtrl.sv
module adcSeqCtrl
  import adcSeqPkg::*;
#(
  parameter int CHAN_W    = 3,
  parameter int RAW_W     = 10,
  parameter int SLOT_W    = 16,
  parameter int NUM_SLOTS = 8,
  parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic [IDX_W-1:0]  seqLenCode,
  output logic [CHAN_W-1:0] convChannel,
  output logic              convStart,
  input  logic              convDone,
  input  logic [RAW_W-1:0]  convData,
  input  logic [IDX_W-1:0]  resultRdIdx,
  output logic [SLOT_W-1:0] resultRdData,
  output logic              seqComplete
);
  seqStrobe_t strobe;
  logic       lastConv;
  logic       scanEn;

  adcSeqControl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .convDone  (convDone),
    .lastConv  (lastConv),
    .scanEn    (scanEn),
    .convStart (convStart),
    .strobe    (strobe)
  );

  adcSeqDatapath #(
    .CHAN_W(CHAN_W), .RAW_W(RAW_W), .SLOT_W(SLOT_W),
    .NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .regWrEn      (regWrEn),
    .regWrData    (regWrData),
    .strobe       (strobe),
    .seqLenCode   (seqLenCode),
    .convData     (convData),
    .resultRdIdx  (resultRdIdx),
    .regRdData    (regRdData),
    .convChannel  (convChannel),
    .resultRdData (resultRdData),
    .seqComplete  (seqComplete),
    .lastConv     (lastConv),
    .scanEn       (scanEn)
  );
endmodule

// File: rtl/adcSeqCtrl_chk.sv
module adcSeqCtrl_chk #(
  parameter int CHAN_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [7:0]        regWrData,
  input logic [7:0]        regRdData,
  input logic [CHAN_W-1:0] convChannel,
  input logic              convStart,
  input logic              seqComplete
);
  AST_CTRL_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> regRdData == ($past(regWrData) & 8'hF7)); // R1

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart); // R2

  AST_SINGLE_CHANNEL: assert property (@(posedge clk) disable iff (!rstN)
    (convStart && !regRdData[4]) |-> convChannel == regRdData[CHAN_W-1:0]); // R5

  AST_WRITE_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !seqComplete); // R9

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (seqComplete && !regWrEn) |=> seqComplete); // R9
endmodule

bind adcSeqCtrl adcSeqCtrl_chk #(.CHAN_W(CHAN_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .regWrEn     (regWrEn),
  .regWrData   (regWrData),
  .regRdData   (regRdData),
  .convChannel (convChannel),
  .convStart   (convStart),
  .seqComplete (seqComplete)
);

// File: tb/adcSeqCtrl_tb.sv
module adcSeqCtrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 3;
  localparam int LOG_N = 8192;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic [2:0]  seqLenCode = '0;
  logic [2:0]  convChannel;
  logic        convStart;
  logic        convDone = 1'b0;
  logic [9:0]  convData = '0;
  logic [2:0]  resultRdIdx = '0;
  logic [15:0] resultRdData;
  logic        seqComplete;

  int nChecks = 0;
  int nFails  = 0;
  bit doneRun = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adcSeqCtrl u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .seqLenCode(seqLenCode), .convChannel(convChannel),
    .convStart(convStart), .convDone(convDone), .convData(convData),
    .resultRdIdx(resultRdIdx), .resultRdData(resultRdData),
    .seqComplete(seqComplete)
  );

  // Converter model: fixed latency, one conversion at a time, logs each start.
  int         serial = 0;
  int         overlap = 0;
  logic       pending = 1'b0;
  int         cnt = 0;
  logic [9:0] pendRaw = '0;
  logic [2:0] logChan [LOG_N];
  logic [9:0] logRaw  [LOG_N];

  always @(posedge clk) begin
    convDone <= 1'b0;
    if (convStart) begin
      if (pending) overlap <= overlap + 1;
      pending <= 1'b1;
      cnt     <= LAT;
      pendRaw <= 10'((serial * 37 + int'(convChannel) * 11 + 3) % 1024);
      logChan[serial % LOG_N] <= convChannel;
      logRaw[serial % LOG_N]  <= 10'((serial * 37 + int'(convChannel) * 11 + 3) % 1024);
      serial  <= serial + 1;
    end else if (pending) begin
      if (cnt == 1) begin
        convDone <= 1'b1;
        convData <= pendRaw;
        pending  <= 1'b0;
      end else begin
        cnt <= cnt - 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int fmtExp(input int raw, input bit rj, input bit sg);
    if (rj) return raw;
    if (sg) return (raw ^ 512) * 64;
    return raw * 64;
  endfunction

  int base = 0;

  task automatic writeCtrl(input logic [7:0] v, input bit immediate);
    if (!immediate) @(negedge clk);
    regWrEn   = 1'b1;
    regWrData = v;
    @(negedge clk);
    regWrEn = 1'b0;
    base = serial;
  endtask

  task automatic waitComplete(input string req);
    int k = 0;
    while (!seqComplete && k < 500) begin
      @(negedge clk);
      k++;
    end
    chk(seqComplete == 1'b1, req, int'(seqComplete), 1);
  endtask

  task automatic checkSlots(input int len, input int b, input bit rj, input bit sg,
                            input string req);
    for (int n = 0; n < len; n++) begin
      resultRdIdx = 3'(n);
      #1;
      chk(int'(resultRdData) == fmtExp(int'(logRaw[(b + n) % LOG_N]), rj, sg), req,
          int'(resultRdData), fmtExp(int'(logRaw[(b + n) % LOG_N]), rj, sg));
    end
  endtask

  task automatic finishRun();
    if (!doneRun) begin
      doneRun = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(regRdData == 8'h00, "R1 reset ctrl", int'(regRdData), 0);
    chk(seqComplete == 1'b0, "R9 reset flag", int'(seqComplete), 0);
    chk(convStart == 1'b0, "R3 reset idle", int'(convStart), 0);
    for (int n = 0; n < 8; n++) begin
      resultRdIdx = 3'(n);
      #1;
      chk(resultRdData == 16'h0, "R9 reset slot", int'(resultRdData), 0);
    end

    // Sweep over format, channel mode, start channel and length (single mode)
    for (int rj = 0; rj < 2; rj++)
      for (int sg = 0; sg < 2; sg++)
        for (int mu = 0; mu < 2; mu++)
          for (int code = 0; code < 8; code++)
            for (int lc = 0; lc < 8; lc++) begin
              logic [7:0] v;
              v = 8'((rj << 7) | (sg << 6) | (mu << 4) | code);
              seqLenCode = 3'(lc);
              writeCtrl(v | 8'h08, 0);
              chk(regRdData == v, "R1 readback bit3 zero", int'(regRdData), int'(v));
              chk(convStart == 1'b1 && int'(convChannel) == code, "R2 start after write",
                  int'({convStart, convChannel}), 8 + code);
              chk(seqComplete == 1'b0, "R9 flag cleared by write", int'(seqComplete), 0);
              waitComplete("R9 flag set at end");
              repeat (8) @(negedge clk);
              chk(serial - base == lc + 1, "R3 R7 conversion count", serial - base, lc + 1);
              for (int n = 0; n <= lc; n++) begin
                int expCh;
                expCh = (mu != 0) ? (code + n) % 8 : code;
                chk(int'(logChan[(base + n) % LOG_N]) == expCh,
                    (mu != 0) ? "R6 stepped channel" : "R5 fixed channel",
                    int'(logChan[(base + n) % LOG_N]), expCh);
              end
              checkSlots(lc + 1, base, rj[0], sg[0], "R8 R9 slot format");
            end

    // R4 continuous scan: length 3, stepping from channel 6
    seqLenCode = 3'd2;
    writeCtrl(8'h36, 0);
    begin
      int k = 0;
      while (serial - base < 7 && k < 500) begin
        @(negedge clk);
        k++;
      end
    end
    for (int i = 0; i < 7; i++)
      chk(int'(logChan[(base + i) % LOG_N]) == (6 + i % 3) % 8, "R4 scan repeats",
          int'(logChan[(base + i) % LOG_N]), (6 + i % 3) % 8);
    chk(seqComplete == 1'b1, "R4 flag during scan", int'(seqComplete), 1);

    // R10 abort inside the wait: stale done discarded
    seqLenCode = 3'd3;
    writeCtrl(8'h12, 0);
    while (!convStart) @(negedge clk);
    @(negedge clk);
    writeCtrl(8'hC5, 1);
    waitComplete("R10 sequence after wait abort");
    repeat (8) @(negedge clk);
    chk(serial - base == 4, "R10 count after wait abort", serial - base, 4);
    for (int n = 0; n < 4; n++)
      chk(int'(logChan[(base + n) % LOG_N]) == 5, "R10 channel after abort",
          int'(logChan[(base + n) % LOG_N]), 5);
    checkSlots(4, base, 1'b1, 1'b1, "R10 R8 slots after wait abort");

    // R10 abort in the start cycle itself
    writeCtrl(8'h03, 0);
    writeCtrl(8'h17, 1);
    waitComplete("R10 sequence after start abort");
    repeat (8) @(negedge clk);
    chk(serial - base == 4, "R10 count after start abort", serial - base, 4);
    for (int n = 0; n < 4; n++)
      chk(int'(logChan[(base + n) % LOG_N]) == (7 + n) % 8, "R6 R10 wrap after abort",
          int'(logChan[(base + n) % LOG_N]), (7 + n) % 8);
    checkSlots(4, base, 1'b0, 1'b0, "R10 R8 slots after start abort");
    chk(overlap == 0, "R10 no start while conversion outstanding", overlap, 0);

    finishRun();
  end
endmodule